// File: doc/BRIEF.md
# A/D Converter Register Serial Programmer

This block loads the eight 8-bit control registers of an analog front-end converter over a three-wire serial link. The link has a serial clock, an active-low load strobe and a data line. After reset the block sends one frame to every register, from address 0 up to address 7, with a built-in default value for each. The registers are configuration, input multiplexer, three colour gains and three colour offsets.

After that power-up burst the block is idle until an operator asks for a change. An image-acquire pulse then sends one frame to the register chosen on a 3-bit address switch, with the value set on an 8-bit data switch.

A mode input hands the serial lines to an outside controller. In that mode the block releases its output enable, parks its lines at their idle levels and starts no frame.

Top module: `adc_serial_prog`

## Requirements
- R1: While reset is held, `ser_load` is 1, `ser_clk` is 0, `ser_data` is 0 and `ser_oe` is 1 (with `ext_mode` low).
- R2: A frame is 16 bits, most significant bit first. It is a 0 (write), then the 3-bit address, then four 0 bits, then the 8-bit data.
- R3: `ser_clk` is the system clock divided by 8. Each bit takes 4 low cycles followed by 4 high cycles, and `ser_load` stays low for exactly 128 cycles per frame.
- R4: `ser_data` changes only where `ser_clk` falls or while it is low. It is stable during every high phase.
- R5: `ser_clk` is low whenever `ser_load` is high. Two frames are separated by at least one cycle with `ser_load` high.
- R6: After reset, eight frames go out for addresses 0, 1, …, 7 in turn, carrying the defaults 0x58, 0xC0, 0x20, 0x20, 0x20, 0x00, 0x00, 0x00.
- R7: A rising edge on `acq_in` while idle sends one frame with the `addr_sw` and `data_sw` values sampled on that edge. Later changes to the switches do not alter that frame.
- R8: A rising edge on `acq_in` while a single-write frame is on the wire is dropped: no further frame follows.
- R9: A rising edge on `acq_in` during the power-up burst is dropped: exactly eight frames are sent.
- R10: `busy` is 1 from the start of the burst to its end and during every frame. It is 0 once `ser_load` has returned high with nothing pending.
- R11: While `ext_mode` is 1, `ser_oe` is 0, the lines sit at their idle levels (load 1, clock 0, data 0), no frame starts and `acq_in` edges are dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_mode | input | 1 | 1 hands the serial lines to an outside controller |
| acq_in | input | 1 | Image-acquire request; its rising edge triggers a write |
| addr_sw | input | 3 | Register address switch |
| data_sw | input | 8 | Register data switch |
| ser_oe | output | 1 | Output enable for the serial lines |
| ser_clk | output | 1 | Serial clock |
| ser_load | output | 1 | Active-low frame strobe |
| ser_data | output | 1 | Serial data |
| busy | output | 1 | Burst or frame in progress |

## Verification
The hardest conditions to reach from the ports are an acquire edge arriving halfway through a frame, and one arriving halfway through the power-up burst. In both cases the only evidence is the absence of an extra frame. The bench therefore forks a frame capture alongside a delayed acquire pulse. It then watches the idle lines for several hundred cycles and counts any stray strobe. Single writes change the switches right after the pulse, so a design that samples them late produces a different frame.

// File: rtl/adc_prog_pkg.sv
// Package: frame layout shared by the serial programmer modules.
// Assumes a write frame of one R/W bit, an address, a zero pad and data.
package adc_prog_pkg;
    localparam int ADDR_W   = 3;
    localparam int DATA_W   = 8;
    localparam int PAD_W    = 4;
    localparam int FRAME_W  = 1 + ADDR_W + PAD_W + DATA_W;
    localparam int NUM_REGS = 1 << ADDR_W;

    typedef struct packed {
        logic              rd_nwr;
        logic [ADDR_W-1:0] addr;
        logic [PAD_W-1:0]  pad;
        logic [DATA_W-1:0] data;
    } frame_t;

    // Builds a write frame with a zero pad field.
    function automatic frame_t mk_write(input logic [ADDR_W-1:0] a,
                                        input logic [DATA_W-1:0] d);
        frame_t f;
        f.rd_nwr = 1'b0;
        f.addr   = a;
        f.pad    = '0;
        f.data   = d;
        return f;
    endfunction
endpackage

// File: rtl/adc_acq_edge.sv
// Module: finds the rising edge of the image-acquire input.
// Assumes acq_in is already synchronous to clk. After reset the previous
// value is taken as 0, so a level held high through reset is seen as an edge.
module adc_acq_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic acq_in,
    output logic acq_rise
);
    logic acq_q;

    // Keeps the previous sample of the acquire input.
    always_ff @(posedge clk) begin
        if (!rst_n) acq_q <= 1'b0;
        else        acq_q <= acq_in;
    end

    // Flags a 0-to-1 transition.
    always_comb acq_rise = acq_in && !acq_q;
endmodule

// File: rtl/adc_frame_tx.sv
// Module: shifts one frame out MSB first on a divided serial clock.
// Assumes DIV is even and at least 2, and that start is raised only while
// active is low. The clock is low for the first half of each bit and high
// for the second. Data moves to the next bit when the clock falls.
module adc_frame_tx
    import adc_prog_pkg::*;
#(
    parameter int DIV = 8
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    input  frame_t word,
    output logic   active,
    output logic   sclk,
    output logic   sdata
);
    localparam int PH_W = (DIV > 2) ? $clog2(DIV) : 1;
    localparam int HALF = DIV / 2;
    localparam int BC_W = $clog2(FRAME_W);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(DIV - 1);
    localparam logic [PH_W-1:0] PH_HALF = PH_W'(HALF);
    localparam logic [BC_W-1:0] BIT_LAST = BC_W'(FRAME_W - 1);

    logic [FRAME_W-1:0] shreg;
    logic [BC_W-1:0]    bitcnt;
    logic [PH_W-1:0]    phase;
    logic               bit_end;

    // Marks the last system cycle of a bit period.
    always_comb bit_end = active && (phase == PH_LAST);

    // Frame-active flag: set on start, cleared after the last bit period.
    always_ff @(posedge clk) begin
        if (!rst_n)                             active <= 1'b0;
        else if (start && !active)              active <= 1'b1;
        else if (bit_end && bitcnt == BIT_LAST) active <= 1'b0;
    end

    // Phase counter within a bit period.
    always_ff @(posedge clk) begin
        if (!rst_n)               phase <= '0;
        else if (!active)         phase <= '0;
        else if (phase == PH_LAST) phase <= '0;
        else                      phase <= phase + 1'b1;
    end

    // Bit counter within a frame.
    always_ff @(posedge clk) begin
        if (!rst_n)                 bitcnt <= '0;
        else if (start && !active)  bitcnt <= '0;
        else if (bit_end)           bitcnt <= bitcnt + 1'b1;
    end

    // Shift register: loads the frame, then shifts left at each bit end.
    always_ff @(posedge clk) begin
        if (!rst_n)                shreg <= '0;
        else if (start && !active) shreg <= word;
        else if (bit_end)          shreg <= {shreg[FRAME_W-2:0], 1'b0};
    end

    // Serial clock: high in the second half of each bit period.
    always_comb sclk = active && (phase >= PH_HALF);

    // Serial data: current MSB while a frame is active.
    always_comb sdata = active && shreg[FRAME_W-1];
endmodule

// File: rtl/adc_prog_seq.sv
// Module: chooses which frame to send next.
// After reset it walks every register with its default value. After that it
// takes single writes from the switches on an accepted acquire edge. An edge
// is accepted only while nothing is pending or in flight and the internal
// mode is selected.
module adc_prog_seq
    import adc_prog_pkg::*;
#(
    parameter logic [NUM_REGS*DATA_W-1:0] DEFAULTS = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_mode,
    input  logic              acq_rise,
    input  logic [ADDR_W-1:0] addr_sw,
    input  logic [DATA_W-1:0] data_sw,
    input  logic              tx_active,
    output logic              start,
    output frame_t            word,
    output logic              busy
);
    localparam logic [ADDR_W-1:0] IDX_LAST = ADDR_W'(NUM_REGS - 1);

    logic              init_pend;
    logic [ADDR_W-1:0] init_idx;
    logic              one_pend;
    logic [ADDR_W-1:0] one_addr;
    logic [DATA_W-1:0] one_data;
    logic              accept;
    logic [DATA_W-1:0] def_val;

    // Busy while the burst or a single write is pending or on the wire.
    always_comb busy = init_pend || one_pend || tx_active;

    // Accepts an acquire edge only when fully idle in internal mode.
    always_comb accept = acq_rise && !busy && !ext_mode;

    // Starts a frame when work is pending and the transmitter is free.
    always_comb start = (init_pend || one_pend) && !tx_active && !ext_mode;

    // Selects the default for the current burst index.
    always_comb def_val = DEFAULTS[init_idx*DATA_W +: DATA_W];

    // Frame source: the burst has priority over a single write.
    always_comb begin
        if (init_pend) word = mk_write(init_idx, def_val);
        else           word = mk_write(one_addr, one_data);
    end

    // Power-up burst progress.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            init_pend <= 1'b1;
            init_idx  <= '0;
        end else if (start && init_pend) begin
            if (init_idx == IDX_LAST) init_pend <= 1'b0;
            init_idx <= init_idx + 1'b1;
        end
    end

    // Single-write request: latched on accept, cleared when its frame starts.
    always_ff @(posedge clk) begin
        if (!rst_n)                      one_pend <= 1'b0;
        else if (accept)                 one_pend <= 1'b1;
        else if (start && !init_pend)    one_pend <= 1'b0;
    end

    // Captures the switch values on the accepted edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            one_addr <= '0;
            one_data <= '0;
        end else if (accept) begin
            one_addr <= addr_sw;
            one_data <= data_sw;
        end
    end
endmodule

// File: rtl/adc_serial_prog.sv
// Module: top of the converter register programmer.
// Connects the edge detector, the sequencer and the frame transmitter, and
// parks the serial lines when an outside controller owns them.
// Assumes all inputs are synchronous to clk.
module adc_serial_prog
    import adc_prog_pkg::*;
#(
    parameter int DIV = 8,
    parameter logic [NUM_REGS*DATA_W-1:0] DEFAULTS = 64'h00_00_00_20_20_20_C0_58
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_mode,
    input  logic              acq_in,
    input  logic [ADDR_W-1:0] addr_sw,
    input  logic [DATA_W-1:0] data_sw,
    output logic              ser_oe,
    output logic              ser_clk,
    output logic              ser_load,
    output logic              ser_data,
    output logic              busy
);
    logic   acq_rise;
    logic   start;
    logic   tx_active;
    logic   tx_sclk;
    logic   tx_sdata;
    frame_t word;

    adc_acq_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .acq_in   (acq_in),
        .acq_rise (acq_rise)
    );

    adc_prog_seq #(.DEFAULTS(DEFAULTS)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_mode  (ext_mode),
        .acq_rise  (acq_rise),
        .addr_sw   (addr_sw),
        .data_sw   (data_sw),
        .tx_active (tx_active),
        .start     (start),
        .word      (word),
        .busy      (busy)
    );

    adc_frame_tx #(.DIV(DIV)) u_tx (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .word   (word),
        .active (tx_active),
        .sclk   (tx_sclk),
        .sdata  (tx_sdata)
    );

    // Output stage: idle levels and enable released in external mode.
    always_comb begin
        ser_oe   = !ext_mode;
        ser_clk  = !ext_mode && tx_sclk;
        ser_load = ext_mode || !tx_active;
        ser_data = !ext_mode && tx_sdata;
    end
endmodule

// File: rtl/adc_serial_prog_chk.sv
// Module: protocol checker bound to the programmer top.
// Assumes the top's ports only. It measures strobe length with its own counter.
module adc_serial_prog_chk #(
    parameter int DIV = 8,
    parameter int FRAME_W = 16
) (
    input logic clk,
    input logic rst_n,
    input logic ext_mode,
    input logic ser_oe,
    input logic ser_clk,
    input logic ser_load,
    input logic ser_data,
    input logic busy
);
    localparam int LEN = FRAME_W * DIV;
    localparam int LW  = $clog2(LEN + 2);

    logic [LW-1:0] low_len;
    logic          len_ok;

    // Counts cycles with the strobe low.
    always_ff @(posedge clk) begin
        if (!rst_n || ser_load) low_len <= '0;
        else                    low_len <= low_len + 1'b1;
    end

    // Qualifies frames that started in internal mode.
    always_ff @(posedge clk) begin
        if (!rst_n || ext_mode) len_ok <= 1'b0;
        else if (ser_load)      len_ok <= 1'b1;
    end

    AST_DATA_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ser_clk |-> $stable(ser_data));                                  // R4
    AST_CLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ser_load |-> !ser_clk);                                          // R5
    AST_BUSY_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_load |-> busy);                                             // R10
    AST_FRAME_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ser_load) && len_ok && !ext_mode) |-> (low_len == LW'(LEN))); // R3
    AST_EXT_NO_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_mode && $past(ext_mode)) |-> (ser_load && !ser_oe));        // R11
endmodule

bind adc_serial_prog adc_serial_prog_chk #(.DIV(DIV), .FRAME_W(adc_prog_pkg::FRAME_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ext_mode (ext_mode),
    .ser_oe   (ser_oe),
    .ser_clk  (ser_clk),
    .ser_load (ser_load),
    .ser_data (ser_data),
    .busy     (busy)
);

// File: tb/adc_serial_prog_tb.sv
module adc_serial_prog_tb;
    localparam int CLK_P = 10;
    localparam int NV = 6;
    // {addr, data} single-write vectors
    localparam logic [10:0] VEC [NV] = '{
        {3'd0, 8'hFF}, {3'd7, 8'h00}, {3'd5, 8'hA5},
        {3'd2, 8'h3C}, {3'd6, 8'h81}, {3'd3, 8'h7E}};
    localparam logic [7:0] DEFV [8] = '{8'h58, 8'hC0, 8'h20, 8'h20,
                                        8'h20, 8'h00, 8'h00, 8'h00};

    logic clk = 0, rst_n = 0, ext_mode = 0, acq_in = 0;
    logic [2:0] addr_sw = '0;
    logic [7:0] data_sw = '0;
    logic ser_oe, ser_clk, ser_load, ser_data, busy;
    int nchk = 0, nerr = 0;

    always #(CLK_P/2) clk = ~clk;

    adc_serial_prog u_dut (
        .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .acq_in(acq_in),
        .addr_sw(addr_sw), .data_sw(data_sw), .ser_oe(ser_oe),
        .ser_clk(ser_clk), .ser_load(ser_load), .ser_data(ser_data), .busy(busy));

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Captures one frame: bits sampled on clock rises, strobe length, clock period.
    task automatic get_frame(output logic [15:0] w, output int len, output int per,
                             output int nb, output bit hi_ok, output bit busy_ok);
        bit pc = 0; logic pd = 0; int r1 = 0;
        w = '0; len = 0; per = 0; nb = 0; hi_ok = 1; busy_ok = 1;
        while (ser_load) @(negedge clk);
        while (!ser_load) begin
            if (!busy) busy_ok = 0;
            if (ser_clk && pc && ser_data !== pd) hi_ok = 0;
            if (ser_clk && !pc) begin
                w = {w[14:0], ser_data};
                nb++;
                if (nb == 1) r1 = len;
                if (nb == 2) per = len - r1;
            end
            pc = ser_clk; pd = ser_data; len++;
            @(negedge clk);
        end
    endtask

    task automatic frame_checks(input logic [15:0] exp, input string tag);
        logic [15:0] w; int len, per, nb; bit hi_ok, bok;
        get_frame(w, len, per, nb, hi_ok, bok);
        check(w == exp, {tag, " R2 frame word"}, w, exp);
        check(len == 128 && nb == 16, {tag, " R3 strobe length"}, len, 128);
        check(per == 8, {tag, " R3 clock period"}, per, 8);
        check(hi_ok, {tag, " R4 data stable while clock high"}, 0, 1);
        check(bok, {tag, " R10 busy during frame"}, 0, 1);
    endtask

    task automatic pulse(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); addr_sw = a; data_sw = d; acq_in = 1;
        @(negedge clk); acq_in = 0; addr_sw = ~a; data_sw = ~d;
    endtask

    task automatic quiet(input int n, input string tag);
        int bad = 0;
        repeat (n) begin
            @(negedge clk);
            if (!ser_load || ser_clk) bad++;
        end
        check(bad == 0, tag, bad, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        nerr++; nchk++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin : main
        repeat (4) @(negedge clk);
        // R1 reset levels
        check(ser_load && !ser_clk && !ser_data && ser_oe, "R1 reset outputs",
              {ser_load, ser_clk, ser_data, ser_oe}, 4'b1001);
        rst_n = 1;
        // R6 burst, with an acquire edge during frame 3 (R9)
        fork
            begin
                for (int i = 0; i < 8; i++)
                    frame_checks({1'b0, 3'(i), 4'b0, DEFV[i]}, "R6 burst");
            end
            begin
                repeat (300) @(negedge clk);
                pulse(3'd4, 8'h99);
            end
        join
        check(!busy, "R10 busy low after burst", busy, 0);
        quiet(300, "R9 no ninth frame after burst");
        // R7 vector table of single writes
        for (int v = 0; v < NV; v++) begin
            pulse(VEC[v][10:8], VEC[v][7:0]);
            frame_checks({1'b0, VEC[v][10:8], 4'b0, VEC[v][7:0]}, "R7 single write");
            check(!busy, "R10 busy low after write", busy, 0);
        end
        // R8 acquire while a frame is on the wire
        fork
            begin pulse(3'd1, 8'h11); frame_checks({1'b0, 3'd1, 4'b0, 8'h11}, "R8 first write"); end
            begin repeat (40) @(negedge clk); pulse(3'd4, 8'h44); end
        join
        quiet(300, "R8 second edge dropped");
        // R11 external mode
        @(negedge clk); ext_mode = 1;
        @(negedge clk);
        check(!ser_oe && ser_load && !ser_clk && !ser_data, "R11 parked lines",
              {ser_oe, ser_load, ser_clk, ser_data}, 4'b0100);
        pulse(3'd6, 8'h66);
        quiet(200, "R11 no frame in external mode");
        check(!busy, "R11 busy low", busy, 0);
        ext_mode = 0;
        quiet(300, "R11 edge in external mode dropped");
        check(ser_oe, "R11 enable restored", ser_oe, 1);
        // R5 back-to-back single writes keep the strobe high between frames
        pulse(3'd2, 8'h5A);
        frame_checks({1'b0, 3'd2, 4'b0, 8'h5A}, "R5 write");
        check(ser_load && !ser_clk, "R5 idle after frame", {ser_load, ser_clk}, 2'b10);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule